// File: doc/BRIEF.md
# HDLC receive frame status generator

This block sits at the tail of a bit-level HDLC receiver. Flag detection, bit destuffing and CRC checking happen upstream and arrive here as single-cycle strobes and level inputs. Between an opening and a closing flag the block counts the destuffed data bits of the frame. It also remembers whether the receive data path overflowed and whether an abort was seen. When the closing flag arrives it forms an 8-bit receive status byte. That byte is written into a status register and pushed into the receive FIFO as the final byte of the stored frame, so software can find each frame's status in-band.

Whether a frame is valid depends on its bit length and on the active configuration: the operating mode, the address width, CRC-16 or CRC-32, and whether the received CRC bytes are forwarded to the FIFO. A frame shorter than the lower length bound of that configuration is dropped silently. A frame at or below the upper too-short bound is reported with the valid bit cleared. The length always counts every byte between the flags, CRC bytes included.

Top module: `hdlc_rx_status`

## Requirements
- R1: After reset, stat_reg is 0x00 and fifo_wr, eof_irq and ovf_irq are 0.
- R2: The status byte layout is: bit 7 valid frame, bit 6 overflow, bit 5 crc_ok, bit 4 abort seen, bit 3 ha_match[1], bit 2 ha_match[0], bit 1 cr_bit, bit 0 la_match. The four address bits and crc_ok are sampled in the closing-flag cycle.
- R3: A frame whose bit count is not a multiple of 8 has the valid bit cleared.
- R4: In modes auto (cfg_mode=00) and non-auto (01), let B = 4 with cfg_addr16=1 or B = 3 with cfg_addr16=0, and X = 2 if cfg_crc32=1 else 0. The too-short upper bound is B+X bytes. The lower bound is B-1 when cfg_crc_fwd=1 and B+X when it is 0.
- R5: In transparent mode 0 (cfg_mode=10) the lower and upper bounds both equal 2+X bytes. In transparent mode 1 (11) both equal 3+X bytes. cfg_addr16 and cfg_crc_fwd have no effect in these modes.
- R6: A frame whose whole-byte count (bits/8 rounded down) is below the lower bound produces no FIFO push and no eof_irq, and stat_reg keeps its previous value. A frame of at least the lower bound is reported. Its valid bit is 1 only if it is byte-aligned and longer than the upper bound.
- R7: If ovf_in is high in any cycle of a frame, the overflow bit of that frame's status is 1. ovf_irq pulses for one cycle, one cycle after the first ovf_in of the frame.
- R8: The overflow and abort memory is cleared at each opening flag, so a frame with no overflow or abort reports 0 in those bits even if the previous frame had them.
- R9: A reported frame causes fifo_wr high for one cycle, one clock after the closing-flag cycle, with fifo_data equal to the new stat_reg. eof_irq pulses the following cycle.
- R10: stat_reg changes only in a cycle where fifo_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 00 auto, 01 non-auto, 10 transparent 0, 11 transparent 1 |
| cfg_addr16 | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| cfg_crc32 | input | 1 | 1 = CRC-32, 0 = CRC-16 |
| cfg_crc_fwd | input | 1 | 1 = received CRC bytes forwarded to FIFO |
| flag_open | input | 1 | Opening flag strobe |
| flag_close | input | 1 | Closing flag strobe (end of frame) |
| bit_valid | input | 1 | One destuffed data bit received |
| ovf_in | input | 1 | Receive data path overflow strobe |
| abort_in | input | 1 | Abort sequence detected |
| crc_ok | input | 1 | CRC check result for the frame |
| ha_match | input | 2 | High address byte match result |
| cr_bit | input | 1 | Command/response bit of the address |
| la_match | input | 1 | Low address byte match result |
| stat_reg | output | 8 | Status of the most recent reported frame |
| fifo_wr | output | 1 | FIFO write strobe for the status byte |
| fifo_data | output | 8 | Status byte written to the FIFO |
| eof_irq | output | 1 | End-of-frame interrupt pulse |
| ovf_irq | output | 1 | Overflow interrupt pulse |

## Verification
A bit counter that is off by one shows up in the valid bit, or as a wrong drop/report decision, at the very next closing flag. The exact-bound frames around each configuration's lower and upper limits expose it within a single frame. Sticky overflow or abort state that is not cleared reveals itself in the status byte of the first clean frame after an erroneous one. A mistimed push or interrupt is visible one or two cycles after the closing flag.

// File: rtl/hdlc_rxs_pkg.sv
package hdlc_rxs_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO    = 2'b00,
    MODE_NONAUTO = 2'b01,
    MODE_TRANSP0 = 2'b10,
    MODE_TRANSP1 = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic vfr;
    logic rdo;
    logic crc;
    logic rab;
    logic ha1;
    logic ha0;
    logic cr;
    logic la;
  } rx_stat_t;
endpackage

// File: rtl/hdlc_rxs_bounds.sv
module hdlc_rxs_bounds #(
  parameter int LEN_W = 4
) (
  input  logic [1:0]       mode,
  input  logic             addr16,
  input  logic             crc32,
  input  logic             crc_fwd,
  output logic [LEN_W-1:0] lo_bytes,
  output logic [LEN_W-1:0] hi_bytes
);
  import hdlc_rxs_pkg::*;

  logic [LEN_W-1:0] extra;
  logic [LEN_W-1:0] base;

  always_comb begin
    extra = crc32 ? LEN_W'(2) : LEN_W'(0);
    base  = addr16 ? LEN_W'(4) : LEN_W'(3);
    case (mode)
      MODE_TRANSP0: begin
        hi_bytes = LEN_W'(2) + extra;
        lo_bytes = hi_bytes;
      end
      MODE_TRANSP1: begin
        hi_bytes = LEN_W'(3) + extra;
        lo_bytes = hi_bytes;
      end
      default: begin
        hi_bytes = base + extra;
        lo_bytes = crc_fwd ? (base - LEN_W'(1)) : hi_bytes;
      end
    endcase
  end

  always_comb begin
    assert (lo_bytes <= hi_bytes && lo_bytes >= LEN_W'(2))
      else $error("a_r4_bounds_order violated");
  end
endmodule

// File: rtl/hdlc_rxs_len_ctr.sv
module hdlc_rxs_len_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_open,
  input  logic             flag_close,
  input  logic             bit_valid,
  input  logic             ovf_in,
  input  logic             abort_in,
  output logic             frame_end,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             ovf_now,
  output logic             abort_now,
  output logic             ovf_irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic in_frame;
  logic ovf_seen;
  logic abort_seen;

  assign frame_end = flag_close & in_frame;
  assign ovf_now   = ovf_seen | (ovf_in & in_frame);
  assign abort_now = abort_seen | (abort_in & in_frame);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame   <= 1'b0;
      bit_cnt    <= '0;
      ovf_seen   <= 1'b0;
      abort_seen <= 1'b0;
      ovf_irq    <= 1'b0;
    end else begin
      ovf_irq <= in_frame & ovf_in & ~ovf_seen & ~flag_open & ~flag_close;
      if (flag_open) begin
        in_frame   <= 1'b1;
        bit_cnt    <= '0;
        ovf_seen   <= 1'b0;
        abort_seen <= 1'b0;
      end else if (frame_end) begin
        in_frame <= 1'b0;
      end else if (in_frame) begin
        if (bit_valid && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (ovf_in) ovf_seen <= 1'b1;
        if (abort_in) abort_seen <= 1'b1;
      end
    end
  end

  a_r8_clear_on_open: assert property (@(posedge clk) disable iff (rst)
    flag_open |=> (bit_cnt == '0 && !ovf_seen && !abort_seen));
  a_r7_irq_from_ovf: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> $past(ovf_in));
  a_r7_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
    (ovf_seen && !flag_open) |=> ovf_seen);
endmodule

// File: rtl/hdlc_rxs_assemble.sv
module hdlc_rxs_assemble #(
  parameter int CNT_W = 12,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic [LEN_W-1:0] lo_bytes,
  input  logic [LEN_W-1:0] hi_bytes,
  input  logic             ovf_now,
  input  logic             abort_now,
  input  logic             crc_ok,
  input  logic [1:0]       ha_match,
  input  logic             cr_bit,
  input  logic             la_match,
  output logic [7:0]       stat_reg,
  output logic             fifo_wr,
  output logic [7:0]       fifo_data,
  output logic             eof_irq
);
  import hdlc_rxs_pkg::*;

  localparam int BYTE_W = CNT_W - 3;

  logic [BYTE_W-1:0] byte_cnt;
  logic [BYTE_W-1:0] lo_x;
  logic [BYTE_W-1:0] hi_x;
  logic              aligned;
  logic              too_small;
  rx_stat_t          st;

  assign byte_cnt  = bit_cnt[CNT_W-1:3];
  assign aligned   = (bit_cnt[2:0] == 3'd0);
  assign lo_x      = BYTE_W'(lo_bytes);
  assign hi_x      = BYTE_W'(hi_bytes);
  assign too_small = (byte_cnt < lo_x);

  always_comb begin
    st.vfr = aligned & (byte_cnt > hi_x);
    st.rdo = ovf_now;
    st.crc = crc_ok;
    st.rab = abort_now;
    st.ha1 = ha_match[1];
    st.ha0 = ha_match[0];
    st.cr  = cr_bit;
    st.la  = la_match;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_reg  <= 8'h00;
      fifo_wr   <= 1'b0;
      fifo_data <= 8'h00;
      eof_irq   <= 1'b0;
    end else begin
      eof_irq <= fifo_wr;
      fifo_wr <= frame_end & ~too_small;
      if (frame_end && !too_small) begin
        stat_reg  <= st;
        fifo_data <= st;
      end
    end
  end

  a_r9_eof_after_push: assert property (@(posedge clk) disable iff (rst)
    eof_irq |-> $past(fifo_wr));
  a_r9_single_push: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |=> !fifo_wr);
  a_r2_fifo_equals_reg: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (fifo_data == stat_reg));
  a_r10_reg_hold: assert property (@(posedge clk) disable iff (rst)
    !fifo_wr |-> $stable(stat_reg));
  a_r6_push_needs_end: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(frame_end));
endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status #(
  parameter int CNT_W = 12,
  parameter int LEN_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_addr16,
  input  logic       cfg_crc32,
  input  logic       cfg_crc_fwd,
  input  logic       flag_open,
  input  logic       flag_close,
  input  logic       bit_valid,
  input  logic       ovf_in,
  input  logic       abort_in,
  input  logic       crc_ok,
  input  logic [1:0] ha_match,
  input  logic       cr_bit,
  input  logic       la_match,
  output logic [7:0] stat_reg,
  output logic       fifo_wr,
  output logic [7:0] fifo_data,
  output logic       eof_irq,
  output logic       ovf_irq
);
  logic             frame_end;
  logic [CNT_W-1:0] bit_cnt;
  logic             ovf_now;
  logic             abort_now;
  logic [LEN_W-1:0] lo_bytes;
  logic [LEN_W-1:0] hi_bytes;

  hdlc_rxs_bounds #(.LEN_W(LEN_W)) u_bounds (
    .mode     (cfg_mode),
    .addr16   (cfg_addr16),
    .crc32    (cfg_crc32),
    .crc_fwd  (cfg_crc_fwd),
    .lo_bytes (lo_bytes),
    .hi_bytes (hi_bytes)
  );

  hdlc_rxs_len_ctr #(.CNT_W(CNT_W)) u_len (
    .clk        (clk),
    .rst        (rst),
    .flag_open  (flag_open),
    .flag_close (flag_close),
    .bit_valid  (bit_valid),
    .ovf_in     (ovf_in),
    .abort_in   (abort_in),
    .frame_end  (frame_end),
    .bit_cnt    (bit_cnt),
    .ovf_now    (ovf_now),
    .abort_now  (abort_now),
    .ovf_irq    (ovf_irq)
  );

  hdlc_rxs_assemble #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_asm (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end),
    .bit_cnt   (bit_cnt),
    .lo_bytes  (lo_bytes),
    .hi_bytes  (hi_bytes),
    .ovf_now   (ovf_now),
    .abort_now (abort_now),
    .crc_ok    (crc_ok),
    .ha_match  (ha_match),
    .cr_bit    (cr_bit),
    .la_match  (la_match),
    .stat_reg  (stat_reg),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .eof_irq   (eof_irq)
  );

  a_r1_no_strobe_in_reset: assert property (@(posedge clk)
    rst |=> (!fifo_wr && !eof_irq && !ovf_irq && stat_reg == 8'h00));
endmodule

// File: tb/sim_hdlc_rx_status.sv
module sim_hdlc_rx_status;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_addr16 = 1'b0;
  logic       cfg_crc32 = 1'b0;
  logic       cfg_crc_fwd = 1'b0;
  logic       flag_open = 1'b0;
  logic       flag_close = 1'b0;
  logic       bit_valid = 1'b0;
  logic       ovf_in = 1'b0;
  logic       abort_in = 1'b0;
  logic       crc_ok = 1'b0;
  logic [1:0] ha_match = 2'b00;
  logic       cr_bit = 1'b0;
  logic       la_match = 1'b0;
  logic [7:0] stat_reg;
  logic       fifo_wr;
  logic [7:0] fifo_data;
  logic       eof_irq;
  logic       ovf_irq;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  logic [7:0] last_stat = 8'h00;

  always #(PERIOD/2) clk = ~clk;

  hdlc_rx_status u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_addr16(cfg_addr16),
    .cfg_crc32(cfg_crc32), .cfg_crc_fwd(cfg_crc_fwd), .flag_open(flag_open),
    .flag_close(flag_close), .bit_valid(bit_valid), .ovf_in(ovf_in),
    .abort_in(abort_in), .crc_ok(crc_ok), .ha_match(ha_match), .cr_bit(cr_bit),
    .la_match(la_match), .stat_reg(stat_reg), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .eof_irq(eof_irq), .ovf_irq(ovf_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // lower bound in [7:4], upper bound in [3:0]
  function automatic logic [7:0] exp_bounds(input logic [1:0] m, input logic a16,
                                            input logic c32, input logic fwd);
    int x, b, lo, hi;
    x = c32 ? 2 : 0;
    if (m == 2'b10) begin hi = 2 + x; lo = hi; end
    else if (m == 2'b11) begin hi = 3 + x; lo = hi; end
    else begin
      b = a16 ? 4 : 3;
      hi = b + x;
      lo = fwd ? b - 1 : hi;
    end
    return {4'(lo), 4'(hi)};
  endfunction

  task automatic send(input int nbits, input int ovf_at, input bit ab, input bit crc,
                      input logic [3:0] adr, input bit gaps, input string req);
    logic [7:0] bnd, exp;
    int lo, hi, nbytes;
    bit rep;
    @(negedge clk) flag_open = 1'b1;
    @(negedge clk) flag_open = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (gaps && ($urandom % 4 == 0)) @(negedge clk);
      bit_valid = 1'b1;
      ovf_in    = (i == ovf_at);
      abort_in  = ab && (i == 0);
      @(negedge clk);
      if (i == ovf_at) check("R7 ovf_irq", {7'd0, ovf_irq}, 8'h01);
      bit_valid = 1'b0;
      ovf_in    = 1'b0;
      abort_in  = 1'b0;
    end
    crc_ok = crc;
    {ha_match, cr_bit, la_match} = adr;
    flag_close = 1'b1;
    @(negedge clk);
    flag_close = 1'b0;
    bnd = exp_bounds(cfg_mode, cfg_addr16, cfg_crc32, cfg_crc_fwd);
    lo = int'(bnd[7:4]);
    hi = int'(bnd[3:0]);
    nbytes = nbits / 8;
    rep = (nbytes >= lo);
    exp[7] = (nbits % 8 == 0) && (nbytes > hi);
    exp[6] = (ovf_at >= 0) && (ovf_at < nbits);
    exp[5] = crc;
    exp[4] = ab && (nbits > 0);
    exp[3:0] = adr;
    if (rep) begin
      check({req, " R9 push"}, {7'd0, fifo_wr}, 8'h01);
      check({req, " R2 fifo_data"}, fifo_data, exp);
      check({req, " R10 stat_reg"}, stat_reg, exp);
      last_stat = exp;
      @(negedge clk);
      check({req, " R9 eof_irq"}, {7'd0, eof_irq}, 8'h01);
      check({req, " R9 single push"}, {7'd0, fifo_wr}, 8'h00);
    end else begin
      check({req, " R6 no push"}, {7'd0, fifo_wr}, 8'h00);
      check({req, " R6 reg kept"}, stat_reg, last_stat);
      @(negedge clk);
      check({req, " R6 no eof"}, {7'd0, eof_irq}, 8'h00);
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] bnd;
    int lo, hi;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 stat_reg", stat_reg, 8'h00);
    check("R1 strobes", {5'd0, fifo_wr, eof_irq, ovf_irq}, 8'h00);

    // R4 and R5: every configuration around its bounds
    for (int c = 0; c < 32; c++) begin
      {cfg_mode, cfg_addr16, cfg_crc32, cfg_crc_fwd} = 5'(c);
      bnd = exp_bounds(cfg_mode, cfg_addr16, cfg_crc32, cfg_crc_fwd);
      lo = int'(bnd[7:4]);
      hi = int'(bnd[3:0]);
      for (int n = lo - 1; n <= hi + 1; n++)
        send(n * 8, -1, 1'b0, 1'b1, 4'b1010, 1'b0, cfg_mode[1] ? "R5 bounds" : "R4 bounds");
      send((hi + 1) * 8 + 3, -1, 1'b0, 1'b1, 4'b0101, 1'b0, "R3 misaligned");
    end

    // R8: errored frame then clean frame
    {cfg_mode, cfg_addr16, cfg_crc32, cfg_crc_fwd} = 5'b00000;
    send(64, 10, 1'b1, 1'b0, 4'b1111, 1'b0, "R7 overflow frame");
    send(64, -1, 1'b0, 1'b1, 4'b0000, 1'b0, "R8 clean frame");
    send(25, -1, 1'b0, 1'b1, 4'b0011, 1'b0, "R3 25 bits");

    // random mix
    for (int k = 0; k < 150; k++) begin
      {cfg_mode, cfg_addr16, cfg_crc32, cfg_crc_fwd} = 5'($urandom);
      send(int'($urandom % 96), ($urandom % 2) ? int'($urandom % 96) : -1,
           1'($urandom), 1'($urandom), 4'($urandom), 1'b1, "R6 random");
    end
    report();
  end
endmodule